// File: doc/BRIEF.md
# Second-Speed Stall Detector with PHY Receiver Override Pulse

This block checks the health of a serial link after training. When the `check_start` strobe arrives, it reads two debug status words from the link controller. The link counts as healthy when the link-up flag is set and the in-training flag is clear. If training is still running, the block waits a fixed number of millisecond ticks and looks again. It does this a bounded number of times. When the link cannot be confirmed, the block looks for one specific failure: a change to the second link speed that has stalled in the receiver-lock recovery state while the PHY reports no valid receive data.

On finding that stall, the block works through an indirect PHY register access port. It reads the receiver override register and sets the data-enable and PLL-enable override bits. It then holds them for a timed window, reads the register again, and clears the same two bits. Every result other than a confirmed link reports `link_ok` low, whether or not the override pulse was applied. If the access master signals a timeout, the sequence stops and a separate error flag is raised.

Top module: `lc_gen2_stall_guard`

## Requirements
- R1: When `dbg_r1` bit 4 (link up) is 1 and bit 29 (in training) is 0 at evaluation, the check ends with `chk_done` pulsing, `link_ok`=1, and no PHY access.
- R2: While bit 4 is 1 and bit 29 is 1, the block re-evaluates after every RETRY_MS ticks of `ms_tick`, at most RETRY_MAX (default 5) extra times. If training is still set after the last retry, the check is treated as failed.
- R3: When bit 4 is 0, the block goes straight to a read of PHY address 0x100D, with no retry wait.
- R4: If bit 0 of the data read from 0x100D (receive valid) is 1, the check ends with `link_ok`=0 and no PHY write. All other bits of that word are ignored.
- R5: A stall is declared only when receive valid is 0 and `dbg_r0[5:0]` equals 0x0D. The upper bits of `dbg_r0` are ignored. With no stall, the check ends after the single read.
- R6: On a stall, the block reads address 0x1005 and writes back the value read with bits 5 and 3 set (OR 0x0028).
- R7: After holding for HOLD_MS ticks, the block reads 0x1005 again and writes back that value with bits 5 and 3 cleared (AND NOT 0x0028). The check then ends.
- R8: Every failed path, including one where the override pulse was applied, ends with `link_ok`=0 and `phy_err`=0.
- R9: A `phy_timeout` response stops the sequence at once. The check ends with `phy_err`=1 and `link_ok`=0, and no further request is issued.
- R10: Only one PHY request is outstanding at a time. `phy_req`, `phy_wr`, `phy_addr` and `phy_wdata` stay stable until `phy_done` or `phy_timeout`.
- R11: After reset, `chk_busy`, `phy_req`, `link_ok`, `phy_err` and `chk_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| check_start | input | 1 | Starts a health check when idle |
| dbg_r0 | input | 32 | Debug word holding the LTSSM state in bits 5:0 |
| dbg_r1 | input | 32 | Debug word with link-up (bit 4) and in-training (bit 29) |
| phy_rdata | input | 16 | Read data from the PHY access master |
| phy_done | input | 1 | Access completed |
| phy_timeout | input | 1 | Access failed by timeout |
| phy_req | output | 1 | Access request, held until completion |
| phy_wr | output | 1 | 1 for write, 0 for read |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | Write data |
| chk_busy | output | 1 | Check in progress |
| chk_done | output | 1 | One-cycle pulse at the end of a check |
| link_ok | output | 1 | Result of the last check |
| phy_err | output | 1 | Last check stopped on a PHY timeout |

## Verification
The assertions assume that the access master answers only a pending request, and with at most one of `phy_done` or `phy_timeout` per request. They also assume that `ms_tick` is a single-cycle pulse. The bench PHY model answers a fixed three cycles after each request rises and never responds while `phy_req` is low. Its tick generator fires once every eight cycles. The debug words change only on tick boundaries placed well away from the retry evaluation points, so that each expected outcome can be decided without ambiguity.

// File: rtl/lc_pkg.sv
package lc_pkg;
    localparam int DBG_W     = 32;
    localparam int PHY_AW    = 16;
    localparam int PHY_DW    = 16;
    localparam int LTSSM_W   = 6;
    localparam int UP_BIT    = 4;
    localparam int TRAIN_BIT = 29;

    localparam logic [LTSSM_W-1:0] LTSSM_RCVR_LOCK = 6'h0D;
    localparam logic [PHY_AW-1:0]  RXSTAT_ADDR     = 16'h100D;
    localparam logic [PHY_AW-1:0]  RXOVR_ADDR      = 16'h1005;
    localparam logic [PHY_DW-1:0]  RXOVR_BITS      = 16'h0028;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_EVAL,
        ST_RETRY,
        ST_RXV,
        ST_OVR_RD1,
        ST_OVR_SET,
        ST_HOLD,
        ST_OVR_RD2,
        ST_OVR_CLR
    } lc_state_e;

    typedef struct packed {
        logic              wr;
        logic [PHY_AW-1:0] addr;
        logic [PHY_DW-1:0] data;
    } phy_cmd_t;

    function automatic logic is_phy_phase(lc_state_e s);
        return (s == ST_RXV) || (s == ST_OVR_RD1) || (s == ST_OVR_SET) ||
               (s == ST_OVR_RD2) || (s == ST_OVR_CLR);
    endfunction

    function automatic logic [PHY_DW-1:0] ovr_apply(logic [PHY_DW-1:0] v, logic set);
        return set ? (v | RXOVR_BITS) : (v & ~RXOVR_BITS);
    endfunction
endpackage

// File: rtl/lc_status_decode.sv
module lc_status_decode
    import lc_pkg::*;
(
    input  logic [DBG_W-1:0]  dbg_r0,
    input  logic [DBG_W-1:0]  dbg_r1,
    input  logic [PHY_DW-1:0] rx_word,
    output logic              link_up,
    output logic              in_train,
    output logic              stall
);
    logic rx_valid;
    logic unused_dbg_bits;

    assign link_up  = dbg_r1[UP_BIT];
    assign in_train = dbg_r1[TRAIN_BIT];
    assign rx_valid = rx_word[0];
    assign stall    = !rx_valid && (dbg_r0[LTSSM_W-1:0] == LTSSM_RCVR_LOCK);

    assign unused_dbg_bits = ^{dbg_r0[DBG_W-1:LTSSM_W], dbg_r1[DBG_W-1:TRAIN_BIT+1],
                               dbg_r1[TRAIN_BIT-1:UP_BIT+1], dbg_r1[UP_BIT-1:0],
                               rx_word[PHY_DW-1:1]};
endmodule

// File: rtl/lc_tick_timer.sv
module lc_tick_timer #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick && !expired) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign expired = (cnt == CW'(LIMIT));

    a_r7_timer_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(LIMIT));
endmodule

// File: rtl/lc_phy_port.sv
module lc_phy_port
    import lc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  phy_cmd_t          cmd,
    input  logic [PHY_DW-1:0] phy_rdata,
    input  logic              phy_done,
    input  logic              phy_timeout,
    output logic              phy_req,
    output logic              phy_wr,
    output logic [PHY_AW-1:0] phy_addr,
    output logic [PHY_DW-1:0] phy_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [PHY_DW-1:0] rsp_data
);
    phy_cmd_t cmd_q;
    logic     req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= 1'b0;
            cmd_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (req_q && (phy_done || phy_timeout)) begin
                req_q     <= 1'b0;
                rsp_valid <= 1'b1;
                rsp_err   <= phy_timeout;
                rsp_data  <= phy_rdata;
            end else if (issue && !req_q) begin
                req_q <= 1'b1;
                cmd_q <= cmd;
            end
        end
    end

    assign phy_req   = req_q;
    assign phy_wr    = cmd_q.wr;
    assign phy_addr  = cmd_q.addr;
    assign phy_wdata = cmd_q.data;

    a_r10_hold_request: assert property (@(posedge clk) disable iff (rst)
        (phy_req && !phy_done && !phy_timeout) |=>
            (phy_req && $stable(phy_wr) && $stable(phy_addr) && $stable(phy_wdata)));

    a_r10_single_outstanding: assert property (@(posedge clk) disable iff (rst)
        issue |-> !phy_req);
endmodule

// File: rtl/lc_gen2_stall_guard.sv
module lc_gen2_stall_guard
    import lc_pkg::*;
#(
    parameter int RETRY_MAX = 5,
    parameter int RETRY_MS  = 1,
    parameter int HOLD_MS   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ms_tick,
    input  logic              check_start,
    input  logic [DBG_W-1:0]  dbg_r0,
    input  logic [DBG_W-1:0]  dbg_r1,
    input  logic [PHY_DW-1:0] phy_rdata,
    input  logic              phy_done,
    input  logic              phy_timeout,
    output logic              phy_req,
    output logic              phy_wr,
    output logic [PHY_AW-1:0] phy_addr,
    output logic [PHY_DW-1:0] phy_wdata,
    output logic              chk_busy,
    output logic              chk_done,
    output logic              link_ok,
    output logic              phy_err
);
    localparam int RW = $clog2(RETRY_MAX + 1);

    lc_state_e         state;
    logic              pend;
    logic [RW-1:0]     retries;
    logic [PHY_DW-1:0] ovr_q;
    logic              issue;
    phy_cmd_t          cmd;
    logic              rsp_valid, rsp_err;
    logic [PHY_DW-1:0] rsp_data;
    logic              link_up, in_train, stall;
    logic              retry_exp, hold_exp;

    lc_status_decode u_decode (
        .dbg_r0   (dbg_r0),
        .dbg_r1   (dbg_r1),
        .rx_word  (rsp_data),
        .link_up  (link_up),
        .in_train (in_train),
        .stall    (stall)
    );

    lc_tick_timer #(.LIMIT(RETRY_MS)) u_retry_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (state != ST_RETRY),
        .tick    (ms_tick),
        .expired (retry_exp)
    );

    lc_tick_timer #(.LIMIT(HOLD_MS)) u_hold_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (state != ST_HOLD),
        .tick    (ms_tick),
        .expired (hold_exp)
    );

    always_comb begin
        cmd = '0;
        case (state)
            ST_RXV:     cmd = '{wr: 1'b0, addr: RXSTAT_ADDR, data: '0};
            ST_OVR_RD1,
            ST_OVR_RD2: cmd = '{wr: 1'b0, addr: RXOVR_ADDR, data: '0};
            ST_OVR_SET: cmd = '{wr: 1'b1, addr: RXOVR_ADDR, data: ovr_apply(ovr_q, 1'b1)};
            ST_OVR_CLR: cmd = '{wr: 1'b1, addr: RXOVR_ADDR, data: ovr_apply(ovr_q, 1'b0)};
            default:    cmd = '0;
        endcase
    end

    assign issue = is_phy_phase(state) && !pend;

    lc_phy_port u_port (
        .clk         (clk),
        .rst         (rst),
        .issue       (issue),
        .cmd         (cmd),
        .phy_rdata   (phy_rdata),
        .phy_done    (phy_done),
        .phy_timeout (phy_timeout),
        .phy_req     (phy_req),
        .phy_wr      (phy_wr),
        .phy_addr    (phy_addr),
        .phy_wdata   (phy_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_err     (rsp_err),
        .rsp_data    (rsp_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pend     <= 1'b0;
            retries  <= '0;
            ovr_q    <= '0;
            link_ok  <= 1'b0;
            phy_err  <= 1'b0;
            chk_done <= 1'b0;
        end else begin
            chk_done <= 1'b0;
            if (issue) pend <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (check_start) begin
                        retries <= '0;
                        link_ok <= 1'b0;
                        phy_err <= 1'b0;
                        state   <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (!link_up) begin
                        state <= ST_RXV;
                    end else if (!in_train) begin
                        link_ok  <= 1'b1;
                        chk_done <= 1'b1;
                        state    <= ST_IDLE;
                    end else if (retries == RW'(RETRY_MAX)) begin
                        state <= ST_RXV;
                    end else begin
                        retries <= retries + RW'(1);
                        state   <= ST_RETRY;
                    end
                end
                ST_RETRY: if (retry_exp) state <= ST_EVAL;
                ST_HOLD:  if (hold_exp)  state <= ST_OVR_RD2;
                default: begin
                    if (rsp_valid) begin
                        pend <= 1'b0;
                        if (rsp_err) begin
                            phy_err  <= 1'b1;
                            chk_done <= 1'b1;
                            state    <= ST_IDLE;
                        end else begin
                            case (state)
                                ST_RXV: begin
                                    if (stall) begin
                                        state <= ST_OVR_RD1;
                                    end else begin
                                        chk_done <= 1'b1;
                                        state    <= ST_IDLE;
                                    end
                                end
                                ST_OVR_RD1: begin
                                    ovr_q <= rsp_data;
                                    state <= ST_OVR_SET;
                                end
                                ST_OVR_SET: state <= ST_HOLD;
                                ST_OVR_RD2: begin
                                    ovr_q <= rsp_data;
                                    state <= ST_OVR_CLR;
                                end
                                default: begin
                                    chk_done <= 1'b1;
                                    state    <= ST_IDLE;
                                end
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    assign chk_busy = (state != ST_IDLE);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !chk_busy |-> !phy_req);

    a_r8_ok_excludes_err: assert property (@(posedge clk) disable iff (rst)
        link_ok |-> !phy_err);

    a_r6_write_target: assert property (@(posedge clk) disable iff (rst)
        (phy_req && phy_wr) |-> (phy_addr == RXOVR_ADDR));

    a_r2_retry_bound: assert property (@(posedge clk) disable iff (rst)
        retries <= RW'(RETRY_MAX));

    a_r9_abort_quiet: assert property (@(posedge clk) disable iff (rst)
        (chk_done && phy_err) |=> !phy_req);

    a_r1_ok_no_access: assert property (@(posedge clk) disable iff (rst)
        (chk_done && link_ok) |-> !phy_req);
endmodule

// File: tb/test_lc_gen2_stall_guard.sv
module test_lc_gen2_stall_guard;
    localparam int RMAX  = 5;
    localparam int RMS   = 2;
    localparam int HMS   = 3;
    localparam int LAT   = 3;
    localparam int NEVER = 1000000000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ms_tick = 1'b0;
    logic        check_start = 1'b0;
    logic [31:0] dbg_r0 = '0;
    logic [31:0] dbg_r1 = '0;
    logic [15:0] phy_rdata = '0;
    logic        phy_done = 1'b0;
    logic        phy_timeout = 1'b0;
    logic        phy_req, phy_wr, chk_busy, chk_done, link_ok, phy_err;
    logic [15:0] phy_addr, phy_wdata;

    int vectors = 0;
    int fails = 0;
    int tick_cnt = 0;
    int div = 0;
    int up_bit = 0;
    int train_until = 0;
    int rxv_bit = 0;
    int fail_idx = -1;
    int n_txn = 0;
    int wcnt = 0;
    int lat = 0;
    int responded = 0;
    int early_drop = 0;
    int start_tick = 0;
    logic [15:0] ovr_reg = '0;
    logic [15:0] wlog [0:1];
    logic [15:0] alog [0:7];
    logic [15:0] pend_addr = '0;
    int req_tick [0:7];
    int ack_tick [0:7];

    always #2.5 clk = ~clk;

    lc_gen2_stall_guard #(.RETRY_MAX(RMAX), .RETRY_MS(RMS), .HOLD_MS(HMS))
        i_lc_gen2_stall_guard (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .check_start(check_start),
        .dbg_r0(dbg_r0), .dbg_r1(dbg_r1), .phy_rdata(phy_rdata),
        .phy_done(phy_done), .phy_timeout(phy_timeout), .phy_req(phy_req),
        .phy_wr(phy_wr), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
        .chk_busy(chk_busy), .chk_done(chk_done), .link_ok(link_ok), .phy_err(phy_err));

    // tick source, debug word model and PHY access model, all driven at negedge
    always @(negedge clk) begin
        ms_tick = (div == 7);
        div = (div + 1) % 8;
        if (ms_tick) tick_cnt++;
        dbg_r1 = 32'h0000_0200 | (up_bit != 0 ? 32'h10 : 32'h0)
                 | (tick_cnt < train_until ? 32'h2000_0000 : 32'h0);
        phy_done = 1'b0;
        phy_timeout = 1'b0;
        if (phy_req && responded == 0) begin
            if (lat == 0) begin
                pend_addr = phy_addr;
                if (n_txn < 8) begin
                    req_tick[n_txn] = tick_cnt;
                    alog[n_txn] = phy_addr;
                end
            end else if (phy_addr != pend_addr) begin
                early_drop++;
            end
            lat++;
            if (lat == LAT) begin
                if (n_txn == fail_idx) begin
                    phy_timeout = 1'b1;
                end else begin
                    phy_done = 1'b1;
                    if (phy_wr) begin
                        ovr_reg = phy_wdata;
                        if (wcnt < 2) wlog[wcnt] = phy_wdata;
                        wcnt++;
                    end else if (phy_addr == 16'h100D) begin
                        phy_rdata = 16'hFFFE | 16'(rxv_bit);
                    end else if (phy_addr == 16'h1005) begin
                        phy_rdata = ovr_reg;
                    end else begin
                        phy_rdata = 16'hDEAD;
                    end
                end
                if (n_txn < 8) ack_tick[n_txn] = tick_cnt;
                n_txn++;
                responded = 1;
            end
        end else if (!phy_req) begin
            if (responded == 0 && lat > 0) early_drop++;
            responded = 0;
            lat = 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic run_case(input int up, input int train_len, input int rxv,
                            input logic [31:0] r0, input logic [15:0] ovr0, input int fidx);
        int ok_exp, stall, full_txn, exp_txn, err_exp, waited;
        up_bit = up;
        train_until = (train_len < 0) ? NEVER : tick_cnt + train_len;
        rxv_bit = rxv;
        dbg_r0 = r0;
        ovr_reg = ovr0;
        fail_idx = fidx;
        n_txn = 0;
        wcnt = 0;
        repeat (2) @(negedge clk);
        check_start = 1'b1;
        start_tick = tick_cnt;
        @(negedge clk);
        check_start = 1'b0;
        waited = 0;
        while (!chk_done && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        ok_exp   = (up != 0 && train_len >= 0 && train_len <= RMAX * RMS) ? 1 : 0;
        stall    = (ok_exp == 0 && rxv == 0 && (r0 & 32'h3F) == 32'h0D) ? 1 : 0;
        full_txn = ok_exp != 0 ? 0 : (stall != 0 ? 5 : 1);
        if (fidx >= 0 && fidx < full_txn) begin
            exp_txn = fidx + 1;
            err_exp = 1;
        end else begin
            exp_txn = full_txn;
            err_exp = 0;
        end
        check("R1/R8 chk_done seen", 32'(chk_done), 32'd1);
        check("R1/R2/R8 link_ok", 32'(link_ok), 32'(ok_exp));
        check("R9 phy_err", 32'(phy_err), 32'(err_exp));
        repeat (20) @(negedge clk);
        check("R4/R5/R9 request count", 32'(n_txn), 32'(exp_txn));
        check("R9 idle after end", 32'(chk_busy | phy_req), 32'd0);
        if (up == 0 && exp_txn > 0)
            check("R3 immediate status read", 32'(req_tick[0] - start_tick <= 1), 32'd1);
        if (up != 0 && train_len < 0)
            check("R2 retry window ticks", 32'(req_tick[0] - start_tick >= RMAX * RMS &&
                  req_tick[0] - start_tick <= RMAX * RMS + 1), 32'd1);
        if (exp_txn > 0) check("R3 status address", 32'(alog[0]), 32'h100D);
        if (stall != 0 && err_exp == 0) begin
            check("R6 first override read addr", 32'(alog[1]), 32'h1005);
            check("R6 set write data", 32'(wlog[0]), 32'(ovr0 | 16'h0028));
            check("R7 clear write data", 32'(wlog[1]), 32'(ovr0 & ~16'h0028));
            check("R7 second read addr", 32'(alog[3]), 32'h1005);
            check("R7 hold window ticks", 32'(req_tick[3] - ack_tick[2] >= HMS &&
                  req_tick[3] - ack_tick[2] <= HMS + 1), 32'd1);
        end
        if (wcnt > 0 && stall == 0) check("R4/R5 no write", 32'(wcnt), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] r0_set [0:4];
        logic [15:0] ovr_set [0:3];
        r0_set[0] = 32'h0000_000D; r0_set[1] = 32'hFFFF_FFCD; r0_set[2] = 32'h0000_000C;
        r0_set[3] = 32'h0000_002D; r0_set[4] = 32'h0000_004D;
        ovr_set[0] = 16'h0000; ovr_set[1] = 16'hFFFF; ovr_set[2] = 16'h1234; ovr_set[3] = 16'h0028;
        repeat (4) @(negedge clk);
        check("R11 reset busy", 32'(chk_busy), 32'd0);
        check("R11 reset req", 32'(phy_req), 32'd0);
        check("R11 reset link_ok", 32'(link_ok), 32'd0);
        check("R11 reset err", 32'(phy_err | chk_done), 32'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        run_case(1, 0, 1, 32'h0, 16'h0, -1);
        for (int k = 1; k <= 9; k += 2) run_case(1, k, 0, 32'h0D, 16'h5555, -1);
        run_case(1, -1, 1, 32'h0D, 16'h0, -1);
        run_case(1, -1, 0, 32'h0D, 16'h00F0, -1);
        for (int rv = 0; rv < 2; rv++)
            for (int ri = 0; ri < 5; ri++)
                for (int oi = 0; oi < 4; oi++)
                    run_case(0, 0, rv, r0_set[ri], ovr_set[oi], -1);
        for (int f = 0; f < 5; f++) run_case(0, 0, 0, 32'h0D, 16'h0F0F, f);
        check("R10 request held until response", 32'(early_drop), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule